// File: doc/BRIEF.md
# Two-Phase Read Bus Sequencer with Wait-State Stretching

This block sits on the host side of a simple general-purpose external bus and runs read accesses. Each access has two parts. The address phase drives the frame and read strobes together with the address. The data phase keeps only the address on the bus. At the rising clock edge that ends the data phase, the block captures the bus read data and returns it to the host with a one-cycle done pulse.

A peripheral can lengthen either phase through an external ready input. The effect of a low ready level depends on the phase:
- In the address phase, frame, read strobe and address all stay asserted.
- In the data phase, only the address stays asserted.

The ready input is sampled on falling clock edges through a synchronizer. It counts only when the ready-enable input is set, and that setting is only valid with a free-running bus clock. When ready-enable is clear, every access takes exactly two clocks, whatever the ready input does.

Top module: `bus2ph_seq`

## Requirements
- R1: After reset, `bus_frame`, `bus_rd`, `done` and `bus_addr` are all 0, and `req_ready` is 1.
- R2: With `rdy_en` = 0, `bus_rdy_in` is ignored. The address phase lasts one clock and the data phase lasts one clock. `done` goes high for the cycle that begins two rising edges after the edge that accepted the request.
- R3: The synchronizer samples `bus_rdy_in` on two successive falling edges. A level presented just after rising edge k therefore governs the sequencer's decision at rising edge k+2.
- R4: When the synchronized ready is low during the address phase, that phase repeats. `bus_frame` and `bus_rd` stay at 1, and `bus_addr` holds the request address.
- R5: When the synchronized ready is low during the data phase, that phase repeats. `bus_frame` and `bus_rd` stay at 0, and `bus_addr` still holds the request address.
- R6: `bus_din` is captured only at the rising edge that ends the data phase. It is presented on `rdata` while `done` is high, and `done` is high for exactly one cycle.
- R7: With `rdy_en` = 1 and the synchronized ready low, no new access starts. `req_ready` stays 0 and `bus_frame` stays 0 even while `req_valid` is held high.
- R8: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. The next cycle is the address phase, and `req_ready` stays 0 until the block is idle again.
- R9: `bus_rd` is never 1 without `bus_frame`. Outside an access, `bus_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, free running |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_en | input | 1 | 1 = external ready stretches phases; 0 = ready ignored |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Sequencer can accept a request this cycle |
| req_addr | input | AW (16) | Read address from the host |
| done | output | 1 | One-cycle pulse: `rdata` holds captured data |
| rdata | output | DW (32) | Captured read data |
| bus_frame | output | 1 | Frame strobe, high in the address phase |
| bus_rd | output | 1 | Read strobe, high in the address phase |
| bus_addr | output | AW (16) | Address on the bus during an access, 0 otherwise |
| bus_din | input | DW (32) | Read data from the bus |
| bus_rdy_in | input | 1 | External ready, active high |

## Verification
Reads run under four ready patterns:
- No stretch.
- Stretch in the address phase only.
- Stretch in the data phase only.
- Stretch in both phases.

These patterns separate a design that holds the wrong signals in a stretched phase, or mixes up which phase a low ready lengthens, from a correct one.

The same stretch patterns are repeated with ready-enable clear, which shows whether the input is truly ignored. The bench presents valid read data only during the final data cycle, so capturing one edge early or late shows up as wrong data.

A separate sequence holds ready low while a request waits. It shows that no access starts, and it confirms the two-edge synchronizer latency at the exact cycle the request is accepted.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  // A phase may move on when stretching is off or the peripheral is ready.
  function automatic logic may_advance(input logic en, input logic rdy);
    return (!en) || rdy;
  endfunction

  function automatic phase_t next_phase(input phase_t cur,
                                        input logic   start,
                                        input logic   adv);
    phase_t nxt;
    nxt = cur;
    case (cur)
      PH_IDLE: if (start) nxt = PH_ADDR;
      PH_ADDR: if (adv)   nxt = PH_DATA;
      PH_DATA: if (adv)   nxt = PH_IDLE;
      default:            nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  // Value placed on the address pins for a given phase.
  function automatic logic [63:0] pin_addr(input phase_t cur, input logic [63:0] a);
    return (cur == PH_IDLE) ? 64'd0 : a;
  endfunction

endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  // Falling-edge sampling chain; resets to "ready" so an idle bus can start.
  generate
    if (STAGES <= 1) begin : g_single
      logic s;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) s <= 1'b1;
        else        s <= d;
      end
      assign q = s;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import bseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   adv,
  output phase_t phase,
  output logic   in_idle,
  output logic   in_addr,
  output logic   in_data,
  output logic   finish
);
  phase_t ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= next_phase(ph_q, start, adv);
  end

  assign phase   = ph_q;
  assign in_idle = (ph_q == PH_IDLE);
  assign in_addr = (ph_q == PH_ADDR);
  assign in_data = (ph_q == PH_DATA);
  assign finish  = in_data && adv;
endmodule

// File: rtl/rd_capture.sv
module rd_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          finish,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rdata,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (finish) rdata <= din;
    end
  end
endmodule

// File: rtl/bus2ph_seq.sv
module bus2ph_seq
  import bseq_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rdy_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_frame,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_rdy_in
);
  localparam int PADW = 64 - AW;

  // Named internal events, exposed for the bound checker.
  logic    rdy_s;
  logic    rdy_ok;
  logic    start;
  logic    finish;
  logic    in_idle, in_addr, in_data;
  phase_t  phase_q;
  logic [AW-1:0] addr_q;
  logic [63:0]   addr_wide;

  rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_rdy_in),
    .q     (rdy_s)
  );

  assign rdy_ok    = may_advance(rdy_en, rdy_s);
  assign req_ready = in_idle && rdy_ok;
  assign start     = req_valid && req_ready;

  phase_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .adv     (rdy_ok),
    .phase   (phase_q),
    .in_idle (in_idle),
    .in_addr (in_addr),
    .in_data (in_data),
    .finish  (finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (start) addr_q <= req_addr;
  end

  assign addr_wide = pin_addr(phase_q, {{PADW{1'b0}}, addr_q});
  assign bus_addr  = addr_wide[AW-1:0];
  assign bus_frame = in_addr;
  assign bus_rd    = in_addr;

  rd_capture #(.DW(DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .finish (finish),
    .din    (bus_din),
    .rdata  (rdata),
    .done   (done)
  );

  logic unused_ok;
  assign unused_ok = ^{in_data, addr_wide[63:AW]};
endmodule

// File: rtl/bus2ph_seq_chk.sv
module bus2ph_seq_chk
  import bseq_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rdy_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          bus_frame,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    st_bits,
  input logic          adv
);
  phase_t st;
  assign st = phase_t'(st_bits);

  // R9
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> bus_frame);

  // R4
  addr_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_ADDR && !adv) |=> (st == PH_ADDR && bus_frame && bus_rd && $stable(bus_addr)));

  // R5
  data_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_DATA && !adv) |=> (st == PH_DATA && !bus_frame && !bus_rd && $stable(bus_addr)));

  // R2
  fixed_addr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_en && st == PH_ADDR) |=> (st == PH_DATA));

  // R2
  fixed_data_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_en && st == PH_DATA) |=> done);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_frame && !req_ready));
endmodule

bind bus2ph_seq bus2ph_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdy_en    (rdy_en),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .bus_frame (bus_frame),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .st_bits   (phase_q),
  .adv       (rdy_ok)
);

// File: tb/test_bus2ph_seq.sv
module test_bus2ph_seq;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rdy_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          done;
  logic [DW-1:0] rdata;
  logic          bus_frame, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_din = '0;
  logic          bus_rdy_in = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [AW-1:0] addr;
    int            acyc;
    int            dcyc;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  bus2ph_seq #(.AW(AW), .DW(DW)) i_bus2ph_seq (
    .clk(clk), .rst_n(rst_n), .rdy_en(rdy_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .done(done), .rdata(rdata),
    .bus_frame(bus_frame), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_din(bus_din), .bus_rdy_in(bus_rdy_in)
  );

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {a ^ 16'hA5C3, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  // Monitor: counts phase cycles, feeds read data, scores completions.
  int acnt = 0;
  int dcnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      // R9 read strobe only inside frame
      check(!bus_rd || bus_frame, "R9", {62'd0, bus_rd, bus_frame}, 64'd3);
      if (q.size() == 0) begin
        // R9 address is 0 outside an access
        check(bus_addr == '0 && !bus_frame, "R9", 64'(bus_addr), 64'd0);
        bus_din = 32'hBAD0_0000;
      end else begin
        if (bus_frame) begin
          acnt++;
          // R4 address phase carries frame, strobe and address
          check(bus_rd && bus_addr == q[0].addr, "R4", 64'(bus_addr), 64'(q[0].addr));
        end else if (bus_addr != '0) begin
          dcnt++;
          // R5 data phase carries only the address
          check(!bus_rd && bus_addr == q[0].addr, "R5", {bus_rd, 47'd0, bus_addr}, 64'(q[0].addr));
        end
        bus_din = (dcnt == q[0].dcyc && dcnt > 0) ? mem_val(q[0].addr)
                                                 : (32'hDEAD_0000 | 32'(dcnt));
      end
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R6", 64'd1, 64'd0);
        end else begin
          // R6 data captured at the edge ending the data phase
          check(rdata == mem_val(q[0].addr), "R6", 64'(rdata), 64'(mem_val(q[0].addr)));
          // R2/R4 address phase length
          check(acnt == q[0].acyc, "R4 R2 addr-phase length", 64'(acnt), 64'(q[0].acyc));
          // R2/R5 data phase length
          check(dcnt == q[0].dcyc, "R5 R2 data-phase length", 64'(dcnt), 64'(q[0].dcyc));
          void'(q.pop_front());
        end
        acnt = 0;
        dcnt = 0;
      end
    end
  end

  // Driver: one read with a stall in each phase (counts in cycles).
  task automatic do_read(input bit en, input logic [AW-1:0] a, input int as, input int ds);
    exp_t e;
    @(posedge clk); #1;
    rdy_en     = en;
    req_valid  = 1'b1;
    req_addr   = a;
    e.addr = a;
    e.acyc = en ? as + 1 : 1;
    e.dcyc = en ? ds + 1 : 1;
    q.push_back(e);
    for (int k = 0; k <= as + ds + 6; k++) begin
      bus_rdy_in = !((k < as) || (k >= as + 1 && k < as + 1 + ds));
      @(posedge clk); #1;
      if (k == 0) begin
        req_valid = 1'b0;
        // R8 accepted and now busy in the address phase
        check(bus_frame && !req_ready, "R8", {62'd0, bus_frame, req_ready}, 64'd2);
      end
    end
    bus_rdy_in = 1'b1;
    // R6 every pushed read has completed
    check(q.size() == 0, "R6 completion", 64'(q.size()), 64'd0);
  endtask

  initial begin
    #22;
    // R1 reset state
    check(!bus_frame && !bus_rd && !done && bus_addr == '0, "R1",
          {bus_frame, bus_rd, done, 45'd0, bus_addr}, 64'd0);
    check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2 plain reads, ready ignored while stretches are requested
    do_read(1'b0, 16'h0011, 0, 0);
    do_read(1'b0, 16'h0012, 3, 0);
    do_read(1'b0, 16'h0013, 0, 4);
    // R4 R5 stretched reads
    do_read(1'b1, 16'h0101, 0, 0);
    do_read(1'b1, 16'h0102, 3, 0);
    do_read(1'b1, 16'h0103, 0, 2);
    do_read(1'b1, 16'h0104, 2, 5);

    // R7 no start while ready low; R3 two-edge latency
    @(posedge clk); #1;
    rdy_en = 1'b1;
    bus_rdy_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    req_valid = 1'b1;
    req_addr  = 16'h0777;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check(!req_ready && !bus_frame, "R7", {62'd0, req_ready, bus_frame}, 64'd0);
    end
    begin
      exp_t e;
      e.addr = 16'h0777; e.acyc = 1; e.dcyc = 1;
      q.push_back(e);
    end
    bus_rdy_in = 1'b1;            // presented just after edge r
    @(posedge clk); #1;           // after edge r+1
    check(!req_ready, "R3 not yet", 64'(req_ready), 64'd0);
    @(negedge clk); #1;           // after falling edge r+1
    check(req_ready, "R3 now ready", 64'(req_ready), 64'd1);
    @(posedge clk); #1;           // edge r+2 accepts
    req_valid = 1'b0;
    check(bus_frame, "R3 R8 accepted at r+2", 64'(bus_frame), 64'd1);
    repeat (4) @(posedge clk);
    #1;
    check(q.size() == 0, "R7 completion", 64'(q.size()), 64'd0);

    // Random mix
    for (int t = 0; t < 40; t++) begin
      do_read(1'($urandom_range(0, 1)), 16'(16'h1000 + t), $urandom_range(0, 4), $urandom_range(0, 4));
    end

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule